// File: doc/BRIEF.md
# DAC Sample-and-Hold Refresh Clock Generator

This block produces the periodic strobe that keeps a DAC's sample-and-hold capacitor topped up at the programmed voltage. A divider turns the system clock into a base tick. One sample clock period is a high part followed by a low part, each a whole number of base ticks long. Every waveform begins with a setup phase of one sample clock period, during which the strobe toggles and the capacitor charges. An optional hold phase follows. During the hold phase the strobe stays low for a programmed count of whole sample clock periods to save power. The waveform then starts over.

Software-style configuration goes into shadow registers through a single write strobe. The generator copies them into its working copy only when a new setup phase begins, so a phase is never cut short or stretched by a write. The generator runs only while `enable` is high. A status output reports whether the hold phase is active.

Top module: `dac_shclk_gen`

## Requirements
- R1: The base period lasts `cfg_div + 1` clock cycles. One sample clock period lasts `(H + L)` base periods, where H and L are the effective high and low counts.
- R2: On the first cycle after `enable` is sampled high from idle, `smpl_clk` goes to 1. It stays high for H base periods, then stays low for L base periods. This high-then-low period is the setup phase.
- R3: After the setup phase, when the hold count N is non-zero, `smpl_clk` stays 0 and `in_hold` is 1 for N × (H + L) base periods. The next setup phase then begins.
- R4: A high or low field of 0 behaves as a count of 1.
- R5: With divider, high, low and hold all 0, `smpl_clk` alternates 1,0,1,0 on consecutive cycles and `in_hold` stays 0.
- R6: A configuration write changes the waveform only from the start of the next setup phase. The phase in progress completes with the old values.
- R7: One cycle after `enable` is sampled low, `smpl_clk` and `in_hold` are both 0. Re-enabling starts again with a fresh setup phase.
- R8: After reset, `smpl_clk` and `in_hold` are 0 and the configuration is all-zero (R5 timing).
- R9: `in_hold` is 0 throughout every setup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator while high |
| cfg_we | input | 1 | Write strobe for the shadow configuration |
| cfg_div | input | DIV_W | Base period minus one, in clock cycles |
| cfg_high | input | PER_W | High time in base periods (0 means 1) |
| cfg_low | input | PER_W | Low time in base periods (0 means 1) |
| cfg_hold | input | HOLD_W | Hold length in sample clock periods |
| smpl_clk | output | 1 | Registered sample clock |
| in_hold | output | 1 | Registered status: 1 during the hold phase |

## Verification
The bench targets four areas:
- **All-zero setting.** A design that mishandled it would stall, or would assert `in_hold` where no hold phase exists.
- **Zero high or low fields.** A design that got these wrong would produce a missing high pulse or a counter wrap lasting many ticks.
- **Writes landing mid-phase.** A premature update would shorten or lengthen the current high, low or hold span.
- **Disable and re-enable at arbitrary points.** A faulty design would leave the strobe high, resume from a stale count instead of a fresh setup phase, or start with a stale prescaler count.

Random configurations with small fields cover the off-by-one edges of every counter.

// File: rtl/dac_shclk_pkg.sv
package dac_shclk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SET_HI = 2'd1,
    ST_SET_LO = 2'd2,
    ST_HOLD   = 2'd3
  } shclk_state_e;
endpackage

// File: rtl/dac_shclk_cfg.sv
module dac_shclk_cfg #(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic [PER_W-1:0]  wr_high,
  input  logic [PER_W-1:0]  wr_low,
  input  logic [HOLD_W-1:0] wr_hold,
  input  logic              load,
  output logic [DIV_W-1:0]  div_o,
  output logic [PER_W-1:0]  high_o,
  output logic [PER_W-1:0]  low_o,
  output logic [HOLD_W-1:0] hold_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [DIV_W-1:0]  sh_div;
  logic [PER_W-1:0]  sh_high, sh_low;
  logic [HOLD_W-1:0] sh_hold;

  // shadow copy, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div  <= '0;
      sh_high <= '0;
      sh_low  <= '0;
      sh_hold <= '0;
    end else if (wr_en) begin
      sh_div  <= wr_div;
      sh_high <= wr_high;
      sh_low  <= wr_low;
      sh_hold <= wr_hold;
    end
  end

  // working copy, refreshed only at a setup-phase start; zero counts become one
  always_ff @(posedge clk) begin
    if (rst) begin
      div_o  <= '0;
      high_o <= ONE;
      low_o  <= ONE;
      hold_o <= '0;
    end else if (load) begin
      div_o  <= sh_div;
      high_o <= (sh_high == '0) ? ONE : sh_high;
      low_o  <= (sh_low == '0) ? ONE : sh_low;
      hold_o <= sh_hold;
    end
  end

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({div_o, high_o, low_o, hold_o}));

  a_r4_counts_nonzero: assert property (@(posedge clk) disable iff (rst)
    (high_o != '0) && (low_o != '0));
endmodule

// File: rtl/dac_shclk_prescale.sv
module dac_shclk_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre;

  assign tick = run && (pre == div);

  always_ff @(posedge clk) begin
    if (rst || !run) pre <= '0;
    else if (pre == div) pre <= '0;
    else pre <= pre + 1'b1;
  end

  a_r1_pre_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre <= div));
endmodule

// File: rtl/dac_shclk_seq.sv
module dac_shclk_seq
  import dac_shclk_pkg::*;
#(
  parameter int PER_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic [PER_W-1:0]  high,
  input  logic [PER_W-1:0]  low,
  input  logic [HOLD_W-1:0] hold,
  output logic              load,
  output logic              run,
  output logic              smpl_clk,
  output logic              in_hold
);
  localparam int SEG_W = PER_W + 1;

  shclk_state_e      state, state_n;
  logic [SEG_W-1:0]  seg, seg_n;
  logic [HOLD_W-1:0] hc, hc_n;
  logic [SEG_W-1:0]  hi_last, lo_last, per_last;

  assign hi_last  = SEG_W'(high) - 1'b1;
  assign lo_last  = SEG_W'(low) - 1'b1;
  assign per_last = SEG_W'(high) + SEG_W'(low) - 1'b1;
  assign run      = (state != ST_IDLE);

  always_comb begin
    state_n = state;
    seg_n   = seg;
    hc_n    = hc;
    load    = 1'b0;
    if (!enable) begin
      state_n = ST_IDLE;
      seg_n   = '0;
      hc_n    = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state_n = ST_SET_HI;
          seg_n   = '0;
          hc_n    = '0;
          load    = 1'b1;
        end
        ST_SET_HI: if (tick) begin
          if (seg == hi_last) begin
            state_n = ST_SET_LO;
            seg_n   = '0;
          end else seg_n = seg + 1'b1;
        end
        ST_SET_LO: if (tick) begin
          if (seg == lo_last) begin
            seg_n = '0;
            hc_n  = '0;
            if (hold == '0) begin
              state_n = ST_SET_HI;
              load    = 1'b1;
            end else state_n = ST_HOLD;
          end else seg_n = seg + 1'b1;
        end
        ST_HOLD: if (tick) begin
          if (seg == per_last) begin
            seg_n = '0;
            if (hc == hold - 1'b1) begin
              state_n = ST_SET_HI;
              hc_n    = '0;
              load    = 1'b1;
            end else hc_n = hc + 1'b1;
          end else seg_n = seg + 1'b1;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      seg      <= '0;
      hc       <= '0;
      smpl_clk <= 1'b0;
      in_hold  <= 1'b0;
    end else begin
      state    <= state_n;
      seg      <= seg_n;
      hc       <= hc_n;
      smpl_clk <= (state_n == ST_SET_HI);
      in_hold  <= (state_n == ST_HOLD);
    end
  end

  a_r7_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!smpl_clk && !in_hold));

  a_r3_hold_silent: assert property (@(posedge clk) disable iff (rst)
    in_hold |-> !smpl_clk);

  a_r9_hold_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(in_hold) |-> $past(!smpl_clk));

  a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
    (!run && enable) |=> smpl_clk);
endmodule

// File: rtl/dac_shclk_gen.sv
module dac_shclk_gen #(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [PER_W-1:0]  cfg_high,
  input  logic [PER_W-1:0]  cfg_low,
  input  logic [HOLD_W-1:0] cfg_hold,
  output logic              smpl_clk,
  output logic              in_hold
);
  logic              load, run, tick;
  logic [DIV_W-1:0]  div_a;
  logic [PER_W-1:0]  high_a, low_a;
  logic [HOLD_W-1:0] hold_a;

  dac_shclk_cfg #(.DIV_W(DIV_W), .PER_W(PER_W), .HOLD_W(HOLD_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_div(cfg_div),
    .wr_high(cfg_high), .wr_low(cfg_low), .wr_hold(cfg_hold),
    .load(load), .div_o(div_a), .high_o(high_a), .low_o(low_a), .hold_o(hold_a)
  );

  dac_shclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div(div_a), .tick(tick)
  );

  dac_shclk_seq #(.PER_W(PER_W), .HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .high(high_a), .low(low_a), .hold(hold_a),
    .load(load), .run(run), .smpl_clk(smpl_clk), .in_hold(in_hold)
  );
endmodule

// File: tb/dac_shclk_gen_bench.sv
module dac_shclk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8, PER_W = 4, HOLD_W = 8;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, cfg_we = 1'b0;
  logic [DIV_W-1:0]  cfg_div  = '0;
  logic [PER_W-1:0]  cfg_high = '0, cfg_low = '0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic smpl_clk, in_hold;

  int n_checks = 0, n_fails = 0, cyc = 0;
  bit done = 1'b0;

  // model state
  bit m_on = 1'b0;
  int m_k = 0;
  int s_div = 0, s_hi = 0, s_lo = 0, s_hold = 0;
  int a_div = 0, a_hi = 1, a_lo = 1, a_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_shclk_gen #(.DIV_W(DIV_W), .PER_W(PER_W), .HOLD_W(HOLD_W)) u_dac_shclk_gen (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_hold(cfg_hold),
    .smpl_clk(smpl_clk), .in_hold(in_hold)
  );

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int full_len();
    return (1 + a_hold) * (a_hi + a_lo) * (a_div + 1);
  endfunction

  function automatic bit exp_clk();
    return m_on && (m_k < a_hi * (a_div + 1));
  endfunction

  function automatic bit exp_hold();
    return m_on && (m_k >= (a_hi + a_lo) * (a_div + 1));
  endfunction

  task automatic load_active();
    a_div = s_div; a_hi = eff(s_hi); a_lo = eff(s_lo); a_hold = s_hold;
  endtask

  task automatic model_edge();
    if (rst) begin
      m_on = 0; m_k = 0; s_div = 0; s_hi = 0; s_lo = 0; s_hold = 0;
      a_div = 0; a_hi = 1; a_lo = 1; a_hold = 0;
      return;
    end
    if (!enable) begin
      m_on = 0; m_k = 0;
    end else if (!m_on) begin
      m_on = 1; m_k = 0; load_active();
    end else begin
      m_k++;
      if (m_k == full_len()) begin
        m_k = 0; load_active();
      end
    end
    if (cfg_we) begin
      s_div = cfg_div; s_hi = cfg_high; s_lo = cfg_low; s_hold = cfg_hold;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    cyc++;
    #1;
    n_checks++;
    if (smpl_clk !== exp_clk() || in_hold !== exp_hold()) begin
      n_fails++;
      $display("FAIL %s cycle %0d: smpl_clk=%0b in_hold=%0b expected smpl_clk=%0b in_hold=%0b",
               tag, cyc, smpl_clk, in_hold, exp_clk(), exp_hold());
    end
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wcfg(input int d, input int h, input int l, input int o, input string tag);
    cfg_we = 1'b1; cfg_div = DIV_W'(d); cfg_high = PER_W'(h);
    cfg_low = PER_W'(l); cfg_hold = HOLD_W'(o);
    step(tag);
    cfg_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    // R8: reset state
    run_n(3, "R8 reset");
    rst = 1'b0;
    run_n(2, "R8 idle after reset");
    // R5: default all-zero config, toggle every cycle
    enable = 1'b1;
    run_n(20, "R5 all-zero toggle");
    enable = 1'b0;
    step("R7 disable");
    // R1 R2 R3 R9: divided waveform with hold phase
    wcfg(2, 3, 2, 2, "R1 cfg");
    enable = 1'b1;
    run_n(100, "R1 R2 R3 R9 waveform");
    // R4: zero high/low with hold
    wcfg(1, 0, 0, 1, "R4 cfg");
    run_n(60, "R4 R6 zero counts after mid-run write");
    // R6: write mid-phase, old values must finish
    run_n(7, "R6 settle");
    wcfg(0, 5, 1, 0, "R6 mid-phase write");
    run_n(40, "R6 new config at next setup");
    // R5 explicit all zero while running
    wcfg(0, 0, 0, 0, "R5 cfg");
    run_n(30, "R5 all-zero applied");
    // R7: disable mid-hold and re-enable
    wcfg(1, 2, 2, 3, "R7 cfg");
    run_n(25, "R7 pre-disable");
    enable = 1'b0;
    run_n(3, "R7 disabled quiet");
    enable = 1'b1;
    run_n(40, "R7 restart from setup");
    // constrained random mix
    for (int t = 0; t < 60; t++) begin
      wcfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), "R6 random write");
      run_n($urandom_range(5, 120), "R1 R2 R3 random run");
      if ($urandom_range(0, 3) == 0) begin
        enable = 1'b0;
        run_n($urandom_range(1, 3), "R7 random disable");
        enable = 1'b1;
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule